// File: doc/BRIEF.md
# Class-D Bridge Mode and Protection Controller

This controller decides, on every clock, how a bridge-output class-D power stage may behave. Two user request levels choose between standby, mute and play. Five fault levels from the analog side drive a protection scheme: supply over- and undervoltage, output overcurrent, an early thermal warning and a thermal shutdown. All five arrive already synchronized. The controller returns a two-bit state code, an enable that drives or tri-states the bridge, and a diagnostic level that models an open-drain pin.

Supply faults clear by themselves: the bridge comes back as soon as the flag drops. An overcurrent is latched. After a programmable number of cycles the bridge is re-enabled for one cycle to see whether the short is still there. The thermal path has two steps, a warning that forces mute and a shutdown that tri-states the bridge. Any path from standby or from a fault towards play goes through a timed mute interval, which keeps the speaker from popping.

Top module: `amp_mode_ctrl`

## Requirements
- R1: The state code is 2 bits: 00 standby, 01 mute, 10 play, 11 fault hi-Z. With no fault, run_req_i low gives state 00 one cycle later with bridge_en_o low, whatever unmute_req_i is. Reset gives state 00, bridge_en_o low and diag_pull_o high.
- R2: With no fault, run_req_i high and unmute_req_i low give state 01 one cycle later with bridge_en_o high (50% duty idle switching).
- R3: On leaving standby or hi-Z, the state holds 01 for exactly SOFT_CYCLES cycles before it moves to 10. A later mute followed by unmute returns to 10 one cycle after unmute_req_i rises.
- R4: ov_flt_i or uv_flt_i high gives state 11 with bridge_en_o low one cycle later. Once the flag clears, the block recovers on its own through R3.
- R5: oc_flt_i sampled high while bridge_en_o is high latches an overcurrent fault, giving state 11 on the next cycle. oc_flt_i while bridge_en_o is low is ignored.
- R6: While the overcurrent latch holds, bridge_en_o stays low for RETRY_CYCLES cycles. It then goes high for exactly one cycle while the state stays 11. If oc_flt_i is high in that cycle, the latch stays set and a new interval starts. Otherwise the next state is 01, or 00 if run_req_i is low.
- R7: tw_flt_i high, with no higher fault, gives state 01 one cycle later even when play is requested. Play resumes one cycle after the warning clears.
- R8: Priority, from highest to lowest: thermal shutdown; then overvoltage, undervoltage and overcurrent; then thermal warning; then the user requests. tsd_flt_i high gives state 11 one cycle later, even with a warning present.
- R9: diag_pull_o is low one cycle after any of tsd, ov, uv or tw is high, or while the overcurrent latch holds. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req_i | input | 1 | High leaves standby |
| unmute_req_i | input | 1 | High requests play, low requests mute |
| ov_flt_i | input | 1 | Supply overvoltage flag |
| uv_flt_i | input | 1 | Supply undervoltage flag |
| oc_flt_i | input | 1 | Output overcurrent flag |
| tw_flt_i | input | 1 | Thermal warning flag |
| tsd_flt_i | input | 1 | Thermal shutdown flag |
| state_o | output | 2 | State code (R1 encoding) |
| bridge_en_o | output | 1 | High drives the bridge, low tri-states it |
| diag_pull_o | output | 1 | High pulls the diagnostic line low (healthy); low releases it |

## Verification
A wrong state register shows on state_o and bridge_en_o one cycle after the input that caused it. A stuck overcurrent latch shows up more slowly, as a missing or misplaced one-cycle enable exactly RETRY_CYCLES cycles into a fault. A wrong soft-start counter shows only as a mute interval of the wrong length before play. The bench therefore compares the full output set against a behavioural model on every cycle, and it measures the retry and soft-start intervals directly in cycles.

// File: rtl/amp_pkg.sv
package amp_pkg;
  typedef enum logic [1:0] {
    AMP_STBY = 2'b00,
    AMP_MUTE = 2'b01,
    AMP_PLAY = 2'b10,
    AMP_HIZ  = 2'b11
  } amp_state_e;
endpackage

// File: rtl/amp_oc_retry.sv
// Overcurrent latch with a timed single-cycle recheck.
module amp_oc_retry #(
  parameter int RETRY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic drive_en,
  input  logic other_hiz,
  output logic lat_next,
  output logic lat_q,
  output logic probe_q
);
  localparam int W = $clog2(RETRY_CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(RETRY_CYCLES - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         probe_d;

  always_comb begin
    if (lat_q) lat_next = probe_q ? oc_flag : 1'b1;
    else       lat_next = oc_flag & drive_en;
    probe_d = 1'b0;
    cnt_d   = '0;
    if (lat_q && !probe_q) begin
      if (cnt_q == LAST) begin
        if (!other_hiz) probe_d = 1'b1;
        else            cnt_d   = cnt_q;   // hold until other faults clear
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= 1'b0;
      probe_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      lat_q   <= lat_next;
      probe_q <= probe_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/amp_soft_timer.sv
// Counts mute cycles after standby or hi-Z; saturates when play is allowed.
module amp_soft_timer #(
  parameter int SOFT_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic ready
);
  localparam int W = $clog2(SOFT_CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(SOFT_CYCLES - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign ready  = (cnt_q == LAST);
  assign cnt_en = clear | ~ready;

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/amp_mode_ctrl.sv
module amp_mode_ctrl
  import amp_pkg::*;
#(
  parameter int RETRY_CYCLES = 1000,
  parameter int SOFT_CYCLES  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_req_i,
  input  logic       unmute_req_i,
  input  logic       ov_flt_i,
  input  logic       uv_flt_i,
  input  logic       oc_flt_i,
  input  logic       tw_flt_i,
  input  logic       tsd_flt_i,
  output logic [1:0] state_o,
  output logic       bridge_en_o,
  output logic       diag_pull_o
);
  amp_state_e state_q, state_d;
  logic diag_q, diag_d;
  logic driving, other_hiz, oc_lat_d, oc_lat_q, oc_probe_q;
  logic soft_clear, soft_ready;

  assign driving     = (state_q == AMP_MUTE) || (state_q == AMP_PLAY);
  assign bridge_en_o = driving | oc_probe_q;
  assign other_hiz   = tsd_flt_i | ov_flt_i | uv_flt_i;
  assign soft_clear  = ~driving;

  amp_oc_retry #(.RETRY_CYCLES(RETRY_CYCLES)) u_oc (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flt_i), .drive_en(bridge_en_o),
    .other_hiz(other_hiz), .lat_next(oc_lat_d), .lat_q(oc_lat_q),
    .probe_q(oc_probe_q)
  );

  amp_soft_timer #(.SOFT_CYCLES(SOFT_CYCLES)) u_soft (
    .clk(clk), .rst_n(rst_n), .clear(soft_clear), .ready(soft_ready)
  );

  // Priority: shutdown > supply/overcurrent > warning > user requests
  always_comb begin
    if (other_hiz || oc_lat_d)         state_d = AMP_HIZ;
    else if (tw_flt_i)                 state_d = AMP_MUTE;
    else if (!run_req_i)               state_d = AMP_STBY;
    else if (!unmute_req_i)            state_d = AMP_MUTE;
    else if (driving && soft_ready)    state_d = AMP_PLAY;
    else                               state_d = AMP_MUTE;
    diag_d = ~(other_hiz | oc_lat_d | tw_flt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AMP_STBY;
      diag_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      diag_q  <= diag_d;
    end
  end

  assign state_o     = state_q;
  assign diag_pull_o = diag_q;
endmodule

// File: rtl/amp_mode_ctrl_chk.sv
module amp_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ov_flt_i,
  input logic       uv_flt_i,
  input logic       oc_flt_i,
  input logic       tw_flt_i,
  input logic       tsd_flt_i,
  input logic [1:0] state_o,
  input logic       bridge_en_o,
  input logic       diag_pull_o
);
  p_stby_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b00 |-> !bridge_en_o);
  p_mute_play_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01 || state_o == 2'b10) |-> bridge_en_o);
  p_stby_not_play_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b00 |=> state_o != 2'b10);
  p_hiz_not_play_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b11 |=> state_o != 2'b10);
  p_supply_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flt_i || uv_flt_i) |=> (state_o == 2'b11 && !bridge_en_o));
  p_oc_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flt_i && bridge_en_o) |=> state_o == 2'b11);
  p_probe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_en_o && state_o == 2'b11) |=> !(bridge_en_o && state_o == 2'b11));
  p_warn_no_play_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tw_flt_i |=> state_o != 2'b10);
  p_tsd_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flt_i |=> state_o == 2'b11);
  p_diag_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_flt_i || ov_flt_i || uv_flt_i || tw_flt_i) |=> !diag_pull_o);
  p_diag_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b11 |-> !diag_pull_o);
endmodule

bind amp_mode_ctrl amp_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ov_flt_i(ov_flt_i), .uv_flt_i(uv_flt_i),
  .oc_flt_i(oc_flt_i), .tw_flt_i(tw_flt_i), .tsd_flt_i(tsd_flt_i),
  .state_o(state_o), .bridge_en_o(bridge_en_o), .diag_pull_o(diag_pull_o)
);

// File: tb/amp_mode_ctrl_bench.sv
`timescale 1ns/1ps
module amp_mode_ctrl_bench;
  localparam int RC = 20;
  localparam int SC = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic run, unm, ov, uv, oc, tw, tsd;
  logic [1:0] st;
  logic en, diag;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  amp_mode_ctrl #(.RETRY_CYCLES(RC), .SOFT_CYCLES(SC)) u_amp_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .run_req_i(run), .unmute_req_i(unm),
    .ov_flt_i(ov), .uv_flt_i(uv), .oc_flt_i(oc), .tw_flt_i(tw),
    .tsd_flt_i(tsd), .state_o(st), .bridge_en_o(en), .diag_pull_o(diag)
  );

  // Behavioural reference model
  int  m_st, m_soft, m_wait;
  bit  m_oc, m_probe, m_diag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_soft = 0; m_wait = 0; m_oc = 0; m_probe = 0; m_diag = 1;
    end else begin
      bit oth, act, noc, nprobe;
      int nwait, nst;
      oth = tsd || ov || uv;
      act = (m_st == 1 || m_st == 2) || m_probe;
      if (m_oc) noc = m_probe ? oc : 1'b1;
      else      noc = oc && act;
      nprobe = 0; nwait = 0;
      if (m_oc && !m_probe) begin
        if (m_wait == RC - 1) begin
          if (!oth) nprobe = 1; else nwait = m_wait;
        end else nwait = m_wait + 1;
      end
      if (oth || noc)        nst = 3;
      else if (tw)           nst = 1;
      else if (!run)         nst = 0;
      else if (!unm)         nst = 1;
      else if ((m_st == 1 || m_st == 2) && m_soft == SC - 1) nst = 2;
      else                   nst = 1;
      if (m_st == 0 || m_st == 3) m_soft = 0;
      else if (m_soft < SC - 1)   m_soft = m_soft + 1;
      m_diag = !(oth || noc || tw);
      m_st = nst; m_oc = noc; m_probe = nprobe; m_wait = nwait;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk(cur_req, "state vs model", int'(st), m_st);
      chk(cur_req, "bridge_en vs model", int'(en),
          int'((m_st == 1 || m_st == 2) || m_probe));
      chk(cur_req, "diag vs model", int'(diag), int'(m_diag));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; run = 0; unm = 0; ov = 0; uv = 0; oc = 0; tw = 0; tsd = 0;
    step(3);
    chk("R1", "reset state", int'(st), 0);
    chk("R1", "reset bridge_en", int'(en), 0);
    chk("R1", "reset diag", int'(diag), 1);
    rst_n = 1'b1; live = 1'b1;

    // R1 standby ignores mute request; R5 overcurrent ignored while undriven
    cur_req = "R1"; unm = 1; step(3); unm = 0; step(2);
    cur_req = "R5"; oc = 1; step(4); oc = 0; step(1);
    chk("R5", "oc ignored in standby state", int'(st), 0);
    chk("R5", "oc ignored in standby diag", int'(diag), 1);

    // R3 soft start
    cur_req = "R3"; run = 1; unm = 1; step(1);
    n = 0;
    while (st == 2'b01 && n < 100) begin n++; step(1); end
    chk("R3", "mute cycles before play", n, SC);
    chk("R3", "play reached", int'(st), 2);

    // R2 mute and quick return
    cur_req = "R2"; unm = 0; step(2);
    chk("R2", "mute state", int'(st), 1);
    chk("R2", "mute drives bridge", int'(en), 1);
    cur_req = "R3"; unm = 1; step(1);
    chk("R3", "unmute returns to play at once", int'(st), 2);

    // R4 supply faults
    cur_req = "R4"; ov = 1; step(3);
    chk("R4", "ov hi-Z", int'(st), 3);
    chk("R4", "ov bridge off", int'(en), 0);
    ov = 0; step(1);
    chk("R4", "ov auto recover to mute", int'(st), 1);
    step(SC + 1);
    chk("R4", "back to play", int'(st), 2);
    uv = 1; step(2);
    chk("R4", "uv hi-Z", int'(st), 3);
    uv = 0; step(SC + 3);

    // R5/R6 overcurrent with one failed recheck
    cur_req = "R5"; oc = 1; step(1);
    chk("R5", "oc trip", int'(st), 3);
    cur_req = "R6"; n = 0;
    while (!(en && st == 2'b11) && n < 200) begin if (st == 2'b11) n++; step(1); end
    chk("R6", "first retry interval", n, RC);
    step(1);
    chk("R6", "relatched after failed probe", int'(st), 3);
    chk("R6", "relatched bridge off", int'(en), 0);
    oc = 0; n = 0;
    while (!(en && st == 2'b11) && n < 200) begin n++; step(1); end
    chk("R6", "second retry interval", n, RC);
    step(1);
    chk("R6", "recovered to mute", int'(st), 1);
    chk("R9", "diag healthy after recovery", int'(diag), 1);
    step(SC + 2);

    // R7 thermal warning
    cur_req = "R7"; tw = 1; step(2);
    chk("R7", "warning forces mute", int'(st), 1);
    chk("R9", "warning releases diag", int'(diag), 0);
    tw = 0; step(1);
    chk("R7", "play resumes", int'(st), 2);

    // R8 shutdown over warning
    cur_req = "R8"; tw = 1; tsd = 1; step(2);
    chk("R8", "shutdown wins over warning", int'(st), 3);
    chk("R9", "shutdown releases diag", int'(diag), 0);
    tsd = 0; step(1);
    chk("R8", "warning left after cooling", int'(st), 1);
    tw = 0; step(SC + 2);

    // R1 back to standby from play
    cur_req = "R1"; run = 0; step(2);
    chk("R1", "standby from play", int'(st), 0);
    chk("R1", "standby bridge off", int'(en), 0);
    step(3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule